// File: doc/BRIEF.md
# Multiplexed LCD Driver with Time-Shared Key Scan

This block drives a passive LCD arranged as three commons by sixteen segments (48 dots) at 1/3 duty and 1/2 bias. Every common and segment output is a 2-bit level code. External analog circuitry turns each code into one of three drive voltages. A `tick` input from the system clock divider paces the display. Each tick ends one time slot. Three display phases, one per common, make a frame, and the drive polarity flips from one frame to the next so that the average voltage across every pixel is zero.

Segments 10 to 15 (counting from 0) also act as source lines for a key matrix. In a key-scan slot exactly one of these six lines is driven high. At the end of the slot the key-sense inputs are latched into one row of a key bitmap. A register interface loads the segment data for each common and sets two mode bits: display enable, and key scanning while the display is on.

The sequencer is a three-state machine. ST_IDLE is the blank start state. ST_DISP drives one display phase. ST_SCAN drives one key-source slot. All transitions happen on a tick:
- IDLE_TO_DISP, when the display is enabled.
- IDLE_TO_SCAN, when it is not.
- DISP_NEXT_PHASE, from phase 0 to 1 or from 1 to 2.
- DISP_FRAME_WRAP, from phase 2 back to phase 0 with the polarity flipped.
- DISP_TO_SCAN, either after phase 2 when scanning during display is set, or at any point once the display is disabled.
- SCAN_TO_DISP, when the display is enabled.
- SCAN_TO_SCAN, when it is not.

Power-on reset, a halted system clock and a chip-enable reset each force the sequencer back to ST_IDLE (HALT_TO_IDLE, CE_TO_IDLE).

Top module: `lcdk_top`

## Requirements
- R1: Level codes are LOW=2'b00, MID=2'b01 and HIGH=2'b10. Common k is `com_lvl[2k+1:2k]` and segment s is `seg_lvl[2s+1:2s]`. The code 2'b11 never appears on any output.
- R2: While `rst_n` is low (power-on reset), all outputs are LOW. Segment data, both mode bits, the key map and the sequencer are cleared.
- R3: With display enable (register 3, bit 0) clear, no segment data is shown. Every output is LOW except the active key-source line in a scan slot.
- R4: In display phase p (p = 0, 1, 2 in order, one phase per tick), common p is HIGH in a positive frame and LOW in a negative frame. The other commons are MID. The polarity toggles after phase 2. The first frame after ST_IDLE is positive.
- R5: Register k (k = 0 to 2) holds the segment data for phase k, with bit s belonging to segment s. In phase k, an on segment is driven to the level opposite the selected common, and an off segment is MID.
- R6: Over any two consecutive display frames (six display phases), the codes on every common and every segment sum to 6, so the average level is MID.
- R7: With the display on and scan-during-display (register 3, bit 1) set, one scan slot follows every phase 2. In that slot all commons and all non-active segments are MID and the active source line is HIGH. With bit 1 clear, no slots are inserted.
- R8: With the display off, every tick is a scan slot. Only the active source line is HIGH and everything else is LOW.
- R9: Source lines are activated in the order segment 10 to segment 15, then back to 10. The period of one line is 24 ticks with the display on and scanning enabled, and 6 ticks with the display off.
- R10: On the tick that ends a scan slot for source j, `key_sense` is stored in `key_map[4j+3:4j]`. The other entries are unchanged, and no entry changes at any other time.
- R11: While `halt` (system clock stopped) is high, all outputs are LOW in the same cycle. Display enable is cleared, the sequencer returns to ST_IDLE and ticks are ignored. Segment data, bit 1 and the key map are kept.
- R12: A `ce_rst` pulse returns the sequencer to ST_IDLE and clears the key map. It keeps the segment data and both mode bits, so the next tick resumes the same mode.
- R13: A register write takes effect on the outputs in the cycle after it is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Power-on reset, active low |
| halt | input | 1 | System clock stopped indication, forces blank |
| ce_rst | input | 1 | Chip-enable reset pulse, keeps display mode |
| tick | input | 1 | One-cycle strobe that ends the current time slot |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | 0 to 2: segment data for phase k; 3: control |
| wr_data | input | 16 | Write data; in control, bit 0 is display enable and bit 1 is scan during display |
| key_sense | input | 4 | Returned key-matrix sense lines |
| com_lvl | output | 6 | Level codes of the three commons |
| seg_lvl | output | 32 | Level codes of the sixteen segments |
| key_map | output | 24 | Latched key bitmap, 4 bits per source line |

## Verification
The state register moves only on the clock edge that samples `tick`, and the outputs are decoded from state without a further register. So every display or scan result is due one cycle after the tick strobe. The bench raises `tick` on a falling edge, drops it on the next falling edge and compares there, against a model that it advances on the same tick. Register writes and `ce_rst` are likewise due one cycle later and are checked at the following falling edge. The effect of `halt` on the outputs is combinational, so the bench checks it a moment after driving `halt`, before any clock edge. Scan periods are measured in ticks between successive slots observed at the ports, and DC balance is summed over six observed display phases.

// File: rtl/lcdk_pkg.sv
package lcdk_pkg;

    typedef enum logic [1:0] {
        LV_LOW  = 2'b00,
        LV_MID  = 2'b01,
        LV_HIGH = 2'b10
    } lvl_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_DISP = 2'b01,
        ST_SCAN = 2'b10
    } seq_e;

endpackage

// File: rtl/lcdk_regs.sv
module lcdk_regs #(
    parameter int N_COM = 3,
    parameter int N_SEG = 16,
    parameter int AW    = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   halt,
    input  logic                   wr_en,
    input  logic [AW-1:0]          wr_addr,
    input  logic [N_SEG-1:0]       wr_data,
    output logic [N_COM*N_SEG-1:0] rows,
    output logic                   disp_en,
    output logic                   scan_w_disp
);

    localparam logic [AW-1:0] CTRL_ADDR = AW'(N_COM);

    for (genvar k = 0; k < N_COM; k++) begin : g_row
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                rows[k*N_SEG +: N_SEG] <= '0;
            end else if (wr_en && wr_addr == AW'(k)) begin
                rows[k*N_SEG +: N_SEG] <= wr_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            disp_en     <= 1'b0;
            scan_w_disp <= 1'b0;
        end else begin
            if (wr_en && wr_addr == CTRL_ADDR) begin
                disp_en     <= wr_data[0];
                scan_w_disp <= wr_data[1];
            end
            if (halt) begin
                disp_en <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/lcdk_seq.sv
module lcdk_seq
    import lcdk_pkg::*;
#(
    parameter int N_COM = 3,
    parameter int N_SRC = 6,
    parameter int PH_W  = 2,
    parameter int SRC_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             halt,
    input  logic             ce_rst,
    input  logic             tick,
    input  logic             disp_en,
    input  logic             scan_w_disp,
    output seq_e             state,
    output logic [PH_W-1:0]  phase,
    output logic             pol,
    output logic [SRC_W-1:0] src,
    output logic             slot_done
);

    localparam logic [PH_W-1:0]  LAST_PH  = PH_W'(N_COM - 1);
    localparam logic [SRC_W-1:0] LAST_SRC = SRC_W'(N_SRC - 1);

    seq_e             st_d;
    logic [PH_W-1:0]  ph_d;
    logic             pol_d;
    logic [SRC_W-1:0] src_d;

    // next-state logic
    always_comb begin
        st_d  = state;
        ph_d  = phase;
        pol_d = pol;
        src_d = src;
        if (tick) begin
            unique case (state)
                ST_IDLE: begin
                    st_d = disp_en ? ST_DISP : ST_SCAN;
                end
                ST_DISP: begin
                    if (!disp_en) begin
                        st_d = ST_SCAN;
                    end else if (phase == LAST_PH) begin
                        ph_d  = '0;
                        pol_d = ~pol;
                        st_d  = scan_w_disp ? ST_SCAN : ST_DISP;
                    end else begin
                        ph_d = phase + PH_W'(1);
                    end
                end
                ST_SCAN: begin
                    src_d = (src == LAST_SRC) ? '0 : src + SRC_W'(1);
                    st_d  = disp_en ? ST_DISP : ST_SCAN;
                end
                default: begin
                    st_d = ST_IDLE;
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            phase <= '0;
            pol   <= 1'b0;
            src   <= '0;
        end else if (halt || ce_rst) begin
            state <= ST_IDLE;
            phase <= '0;
            pol   <= 1'b0;
            src   <= '0;
        end else begin
            state <= st_d;
            phase <= ph_d;
            pol   <= pol_d;
            src   <= src_d;
        end
    end

    // slot strobe
    always_comb begin
        slot_done = tick && (state == ST_SCAN) && !halt && !ce_rst;
    end

endmodule

// File: rtl/lcdk_keymap.sv
module lcdk_keymap #(
    parameter int N_SRC   = 6,
    parameter int SENSE_W = 4,
    parameter int SRC_W   = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       ce_rst,
    input  logic                       slot_done,
    input  logic [SRC_W-1:0]           src,
    input  logic [SENSE_W-1:0]         key_sense,
    output logic [N_SRC*SENSE_W-1:0]   key_map
);

    for (genvar j = 0; j < N_SRC; j++) begin : g_ent
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                key_map[j*SENSE_W +: SENSE_W] <= '0;
            end else if (ce_rst) begin
                key_map[j*SENSE_W +: SENSE_W] <= '0;
            end else if (slot_done && src == SRC_W'(j)) begin
                key_map[j*SENSE_W +: SENSE_W] <= key_sense;
            end
        end
    end

endmodule

// File: rtl/lcdk_drive.sv
module lcdk_drive
    import lcdk_pkg::*;
#(
    parameter int N_COM    = 3,
    parameter int N_SEG    = 16,
    parameter int N_SRC    = 6,
    parameter int SRC_BASE = 10,
    parameter int PH_W     = 2,
    parameter int SRC_W    = 3
) (
    input  logic                   halt,
    input  seq_e                   state,
    input  logic [PH_W-1:0]        phase,
    input  logic                   pol,
    input  logic [SRC_W-1:0]       src,
    input  logic                   disp_en,
    input  logic [N_COM*N_SEG-1:0] rows,
    output logic [2*N_COM-1:0]     com_lvl,
    output logic [2*N_SEG-1:0]     seg_lvl
);

    // level of the selected common and of an on segment in this frame
    lvl_e sel_lvl;
    lvl_e on_lvl;

    always_comb begin
        sel_lvl = pol ? LV_LOW : LV_HIGH;
        on_lvl  = pol ? LV_HIGH : LV_LOW;
    end

    for (genvar k = 0; k < N_COM; k++) begin : g_com
        lvl_e lv;
        always_comb begin
            lv = LV_LOW;
            if (!halt) begin
                unique case (state)
                    ST_DISP: begin
                        if (disp_en) begin
                            lv = (phase == PH_W'(k)) ? sel_lvl : LV_MID;
                        end
                    end
                    ST_SCAN: begin
                        lv = disp_en ? LV_MID : LV_LOW;
                    end
                    default: begin
                        lv = LV_LOW;
                    end
                endcase
            end
        end
        assign com_lvl[2*k +: 2] = lv;
    end

    for (genvar s = 0; s < N_SEG; s++) begin : g_seg
        logic                   act;
        logic [(1<<PH_W)-1:0]   col;
        lvl_e                   lv;

        if (s >= SRC_BASE && s < SRC_BASE + N_SRC) begin : g_src
            assign act = (src == SRC_W'(s - SRC_BASE));
        end else begin : g_plain
            assign act = 1'b0;
        end

        always_comb begin
            col = '0;
            for (int k = 0; k < N_COM; k++) begin
                col[k] = rows[k*N_SEG + s];
            end
        end

        always_comb begin
            lv = LV_LOW;
            if (!halt) begin
                unique case (state)
                    ST_DISP: begin
                        if (disp_en) begin
                            lv = col[phase] ? on_lvl : LV_MID;
                        end
                    end
                    ST_SCAN: begin
                        if (act) begin
                            lv = LV_HIGH;
                        end else begin
                            lv = disp_en ? LV_MID : LV_LOW;
                        end
                    end
                    default: begin
                        lv = LV_LOW;
                    end
                endcase
            end
        end
        assign seg_lvl[2*s +: 2] = lv;
    end

endmodule

// File: rtl/lcdk_top.sv
module lcdk_top
    import lcdk_pkg::*;
#(
    parameter int N_COM    = 3,
    parameter int N_SEG    = 16,
    parameter int N_SRC    = 6,
    parameter int SRC_BASE = 10,
    parameter int SENSE_W  = 4,
    localparam int AW      = $clog2(N_COM + 1)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     halt,
    input  logic                     ce_rst,
    input  logic                     tick,
    input  logic                     wr_en,
    input  logic [AW-1:0]            wr_addr,
    input  logic [N_SEG-1:0]         wr_data,
    input  logic [SENSE_W-1:0]       key_sense,
    output logic [2*N_COM-1:0]       com_lvl,
    output logic [2*N_SEG-1:0]       seg_lvl,
    output logic [N_SRC*SENSE_W-1:0] key_map
);

    localparam int PH_W  = (N_COM > 1) ? $clog2(N_COM) : 1;
    localparam int SRC_W = (N_SRC > 1) ? $clog2(N_SRC) : 1;

    logic [N_COM*N_SEG-1:0] rows;
    logic                   disp_en;
    logic                   scan_w_disp;
    seq_e                   state;
    logic [PH_W-1:0]        phase;
    logic                   pol;
    logic [SRC_W-1:0]       src;
    logic                   slot_done;

    lcdk_regs #(.N_COM(N_COM), .N_SEG(N_SEG), .AW(AW)) u_regs (
        .clk(clk), .rst_n(rst_n), .halt(halt),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rows(rows), .disp_en(disp_en), .scan_w_disp(scan_w_disp)
    );

    lcdk_seq #(.N_COM(N_COM), .N_SRC(N_SRC), .PH_W(PH_W), .SRC_W(SRC_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .halt(halt), .ce_rst(ce_rst), .tick(tick),
        .disp_en(disp_en), .scan_w_disp(scan_w_disp),
        .state(state), .phase(phase), .pol(pol), .src(src), .slot_done(slot_done)
    );

    lcdk_keymap #(.N_SRC(N_SRC), .SENSE_W(SENSE_W), .SRC_W(SRC_W)) u_keys (
        .clk(clk), .rst_n(rst_n), .ce_rst(ce_rst), .slot_done(slot_done),
        .src(src), .key_sense(key_sense), .key_map(key_map)
    );

    lcdk_drive #(
        .N_COM(N_COM), .N_SEG(N_SEG), .N_SRC(N_SRC), .SRC_BASE(SRC_BASE),
        .PH_W(PH_W), .SRC_W(SRC_W)
    ) u_drive (
        .halt(halt), .state(state), .phase(phase), .pol(pol), .src(src),
        .disp_en(disp_en), .rows(rows), .com_lvl(com_lvl), .seg_lvl(seg_lvl)
    );

endmodule

// File: rtl/lcdk_chk.sv
module lcdk_chk #(
    parameter int N_COM   = 3,
    parameter int N_SEG   = 16,
    parameter int N_SRC   = 6,
    parameter int SENSE_W = 4
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     halt,
    input logic                     ce_rst,
    input logic                     tick,
    input logic                     wr_en,
    input logic                     disp_en,
    input logic [2*N_COM-1:0]       com_lvl,
    input logic [2*N_SEG-1:0]       seg_lvl,
    input logic [N_SRC*SENSE_W-1:0] key_map
);

    logic bad_code;

    always_comb begin
        bad_code = 1'b0;
        for (int k = 0; k < N_COM; k++) begin
            if (com_lvl[2*k +: 2] == 2'b11) bad_code = 1'b1;
        end
        for (int s = 0; s < N_SEG; s++) begin
            if (seg_lvl[2*s +: 2] == 2'b11) bad_code = 1'b1;
        end
    end

    AST_NO_CODE3: assert property (@(posedge clk) disable iff (!rst_n)
        !bad_code); // R1

    AST_HALT_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
        halt |-> (com_lvl == '0 && seg_lvl == '0)); // R11

    AST_HALT_CLEARS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        halt |=> !disp_en); // R11

    AST_QUIET_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!tick && !wr_en && !ce_rst && !halt) && !halt)
            |-> ($stable(com_lvl) && $stable(seg_lvl))); // R4

    AST_KEYMAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !ce_rst) |=> $stable(key_map)); // R10

    AST_CE_CLEARS_KEYS: assert property (@(posedge clk) disable iff (!rst_n)
        ce_rst |=> key_map == '0); // R12

    AST_CE_KEEPS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_rst && !wr_en && !halt) |=> $stable(disp_en)); // R12

endmodule

bind lcdk_top lcdk_chk #(
    .N_COM(N_COM), .N_SEG(N_SEG), .N_SRC(N_SRC), .SENSE_W(SENSE_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .halt(halt), .ce_rst(ce_rst), .tick(tick),
    .wr_en(wr_en), .disp_en(disp_en), .com_lvl(com_lvl), .seg_lvl(seg_lvl),
    .key_map(key_map)
);

// File: tb/lcdk_top_test.sv
module lcdk_top_test;

    localparam int NC = 3;
    localparam int NS = 16;
    localparam int NK = 6;
    localparam int SB = 10;
    localparam int KW = 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            halt = 1'b0;
    logic            ce_rst = 1'b0;
    logic            tick = 1'b0;
    logic            wr_en = 1'b0;
    logic [1:0]      wr_addr = '0;
    logic [NS-1:0]   wr_data = '0;
    logic [KW-1:0]   key_sense = '0;
    logic [2*NC-1:0] com_lvl;
    logic [2*NS-1:0] seg_lvl;
    logic [NK*KW-1:0] key_map;

    int n_run = 0;
    int n_fail = 0;

    // reference model
    logic [NS-1:0] m_rows [NC];
    logic          m_den, m_sw, m_halt;
    int            m_st, m_ph, m_pol, m_src;
    logic [KW-1:0] m_kmap [NK];

    always #4 clk = ~clk;

    lcdk_top uut (
        .clk(clk), .rst_n(rst_n), .halt(halt), .ce_rst(ce_rst), .tick(tick),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .key_sense(key_sense), .com_lvl(com_lvl), .seg_lvl(seg_lvl),
        .key_map(key_map)
    );

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        summary();
        $finish;
    end

    task automatic model_clear_seq();
        m_st = 0; m_ph = 0; m_pol = 0; m_src = 0;
    endtask

    task automatic model_por();
        for (int k = 0; k < NC; k++) m_rows[k] = '0;
        m_den = 0; m_sw = 0; m_halt = 0;
        for (int j = 0; j < NK; j++) m_kmap[j] = '0;
        model_clear_seq();
    endtask

    function automatic logic [1:0] exp_com(int k);
        if (m_halt) return 2'b00;
        if (m_st == 1) return m_den ? ((m_ph == k) ? (m_pol ? 2'b00 : 2'b10) : 2'b01) : 2'b00;
        if (m_st == 2) return m_den ? 2'b01 : 2'b00;
        return 2'b00;
    endfunction

    function automatic logic [1:0] exp_seg(int s);
        if (m_halt) return 2'b00;
        if (m_st == 1) begin
            if (!m_den) return 2'b00;
            return m_rows[m_ph][s] ? (m_pol ? 2'b10 : 2'b00) : 2'b01;
        end
        if (m_st == 2) begin
            if (s >= SB && s - SB == m_src) return 2'b10;
            return m_den ? 2'b01 : 2'b00;
        end
        return 2'b00;
    endfunction

    task automatic check_all(string req);
        logic [2*NC-1:0] ec;
        logic [2*NS-1:0] es;
        logic [NK*KW-1:0] ek;
        for (int k = 0; k < NC; k++) ec[2*k +: 2] = exp_com(k);
        for (int s = 0; s < NS; s++) es[2*s +: 2] = exp_seg(s);
        for (int j = 0; j < NK; j++) ek[j*KW +: KW] = m_kmap[j];
        n_run++;
        if (com_lvl !== ec || seg_lvl !== es) begin
            n_fail++;
            $display("FAIL %s: com=%h seg=%h expected com=%h seg=%h", req, com_lvl, seg_lvl, ec, es);
        end
        n_run++;
        if (key_map !== ek) begin
            n_fail++;
            $display("FAIL %s key map: actual=%h expected=%h", req, key_map, ek);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [NS-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        if (a == 2'd3) begin
            m_den = d[0] && !m_halt;
            m_sw = d[1];
        end else begin
            m_rows[a] = d;
        end
    endtask

    task automatic ce_pulse();
        @(negedge clk);
        ce_rst = 1'b1;
        @(negedge clk);
        ce_rst = 1'b0;
        model_clear_seq();
        for (int j = 0; j < NK; j++) m_kmap[j] = '0;
    endtask

    task automatic do_tick(input logic [KW-1:0] ks);
        @(negedge clk);
        tick = 1'b1; key_sense = ks;
        @(negedge clk);
        tick = 1'b0;
        if (!m_halt) begin
            case (m_st)
                0: m_st = m_den ? 1 : 2;
                1: begin
                    if (!m_den) m_st = 2;
                    else if (m_ph == NC - 1) begin
                        m_ph = 0; m_pol ^= 1; m_st = m_sw ? 2 : 1;
                    end else m_ph++;
                end
                default: begin
                    m_kmap[m_src] = ks;
                    m_src = (m_src + 1) % NK;
                    m_st = m_den ? 1 : 2;
                end
            endcase
        end
    endtask

    task automatic period_run(input logic den, input int nt, input int exp_p, string req);
        int last = -1;
        int nhit = 0;
        logic [2*NC-1:0] cref;
        cref = den ? 6'b010101 : 6'b000000;
        for (int t = 1; t <= nt; t++) begin
            do_tick(KW'(t * 7 + 3));
            check_all(req);
            if (seg_lvl[2*SB +: 2] == 2'b10 && com_lvl == cref) begin
                if (last >= 0) begin
                    n_run++;
                    if (t - last != exp_p) begin
                        n_fail++;
                        $display("FAIL R9 period: actual=%0d expected=%0d", t - last, exp_p);
                    end
                end
                last = t;
                nhit++;
            end
        end
        n_run++;
        if (nhit < 2) begin
            n_fail++;
            $display("FAIL R9 slot count: actual=%0d expected>=2", nhit);
        end
    endtask

    initial begin
        model_por();
        repeat (3) @(negedge clk);
        check_all("R2 reset");
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R2 after reset");

        // display sweep with DC balance, several segment patterns
        for (int p = 0; p < 4; p++) begin
            int sc [NC];
            int ss [NS];
            for (int k = 0; k < NC; k++) begin
                logic [NS-1:0] v;
                v = NS'((32'hA5C3 * (p + 1) + 32'h1357 * k) ^ (32'hFFFF * (p == 3 ? k : 0)));
                if (p == 0) v = '0;
                if (p == 1) v = '1;
                wr(2'(k), v);
            end
            check_all("R3 loaded but disabled");
            wr(2'd3, 16'h0001);
            check_all("R13 enable before tick");
            ce_pulse();
            for (int k = 0; k < NC; k++) sc[k] = 0;
            for (int s = 0; s < NS; s++) ss[s] = 0;
            for (int t = 0; t < 2 * NC; t++) begin
                do_tick('0);
                check_all("R4/R5 display phase");
                for (int k = 0; k < NC; k++) sc[k] += int'(com_lvl[2*k +: 2]);
                for (int s = 0; s < NS; s++) ss[s] += int'(seg_lvl[2*s +: 2]);
            end
            for (int k = 0; k < NC; k++) begin
                n_run++;
                if (sc[k] != 2 * NC) begin
                    n_fail++;
                    $display("FAIL R6 common %0d sum: actual=%0d expected=%0d", k, sc[k], 2 * NC);
                end
            end
            for (int s = 0; s < NS; s++) begin
                n_run++;
                if (ss[s] != 2 * NC) begin
                    n_fail++;
                    $display("FAIL R6 segment %0d sum: actual=%0d expected=%0d", s, ss[s], 2 * NC);
                end
            end
        end

        // R13: a row write shows in the next cycle
        wr(2'(m_ph), 16'h00F0);
        check_all("R13 row write");

        // R7/R9/R10: scan during display
        wr(2'd3, 16'h0003);
        ce_pulse();
        period_run(1'b1, 60, 4 * NK, "R7/R10 scan with display");

        // R8/R9/R10: display off, scanning every tick
        wr(2'd3, 16'h0000);
        ce_pulse();
        check_all("R8 idle blank");
        period_run(1'b0, 20, NK, "R8/R10 scan only");

        // R12: chip-enable reset keeps mode
        wr(2'd3, 16'h0001);
        ce_pulse();
        for (int t = 0; t < 4; t++) begin
            do_tick('0);
            check_all("R12 pre");
        end
        ce_pulse();
        check_all("R12 after ce blank");
        do_tick('0);
        check_all("R12 mode kept, phase 0");

        // R11: clock stop
        wr(2'd3, 16'h0003);
        ce_pulse();
        for (int t = 0; t < 6; t++) begin
            do_tick(KW'(t + 9));
            check_all("R11 pre");
        end
        @(negedge clk);
        halt = 1'b1;
        m_halt = 1'b1;
        m_den = 1'b0;
        model_clear_seq();
        #1;
        check_all("R11 immediate blank");
        do_tick(4'hF);
        check_all("R11 tick ignored");
        wr(2'd3, 16'h0003);
        check_all("R11 enable blocked");
        @(negedge clk);
        halt = 1'b0;
        m_halt = 1'b0;
        @(negedge clk);
        check_all("R11 released idle");
        do_tick(4'h6);
        check_all("R11 display cleared, scanning");

        // R2: power-on reset mid-run
        @(negedge clk);
        rst_n = 1'b0;
        model_por();
        @(negedge clk);
        check_all("R2 por blank");
        rst_n = 1'b1;
        do_tick(4'h5);
        check_all("R2 regs cleared");

        summary();
        $finish;
    end

endmodule